// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Slave

This block lets an external controller program and inspect a byte-wide register file over three wires: a serial clock, an active-low select and one shared data line. The data line is split at the block edge into an input, an output and an output-enable, so a pad or top-level tri-state buffer can merge them. The serial pins are oversampled in the system clock domain. Every transfer is handled there, with no logic clocked by the serial clock.

A transfer opens with a 16-bit command that carries the direction, a length code and a 13-bit start address. Data bytes follow the command. On a write, each completed byte is stored at the current address. On a read, the block starts driving the shared line once the command ends and shifts register contents out. The address moves by one after every byte. Its direction and the bit order of the data bytes both follow a bit in the configuration register at address 0. The controller may pause with the select high at byte boundaries. It may also hold the select low and stream bytes for as long as it likes.

Top module: `spi3w_cfg_slave`

## Requirements
- R1: After reset the output-enable is 0, the serial output is 0 and data bytes use MSB-first order. Register contents are undefined until written.
- R2: The command is always shifted MSB-first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address.
- R3: Length codes 00, 01 and 10 carry exactly 1, 2 and 3 data bytes. After the last byte the frame is over, and further clock pulses are ignored until the select falls again.
- R4: Length code 11 streams data bytes with no limit until the select rises at a byte boundary.
- R5: In a write frame every complete data byte is stored at the current address, and a later read returns it.
- R6: In a read frame the output-enable rises after the 16th command bit and stays high while the select is low during the data bytes. In a write frame it stays 0, and no register is written during a read.
- R7: While the select is high the output-enable is 0 within 4 system clock cycles.
- R8: Raising the select after a whole number of bytes has been shifted keeps the frame position. This applies after command bit 8 and after any data byte of a frame with bytes still to come. The frame then resumes at the next falling select.
- R9: Raising the select partway through a byte (or partway through the command) abandons the frame, and the partial byte is not written.
- R10: Bit 0 of the register at address 0 selects the data bit order: 1 = LSB-first, 0 = MSB-first. A new value takes effect from the byte after the one that wrote it.
- R11: After each data byte the address goes down by one in MSB-first mode and up by one in LSB-first mode, modulo 2^13. Registers are selected by the address modulo the register count (32 by default).
- R12: Input bits are taken at the serial clock's rising edge, and output bits change only after its falling edge. Each serial clock phase must last at least 4 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_csn | input | 1 | Active-low select |
| spi_sdi | input | 1 | Shared data line, input side |
| spi_sdo | output | 1 | Shared data line, output side |
| spi_sdo_oe | output | 1 | Drive enable for the shared data line |

## Verification
The hardest situation to reach is a read frame that pauses at a byte boundary. At the pause the line has to go quiet, and on resuming it must present the next register's first bit, in the current bit order, before any new rising clock edge. The stimulus gets there by running read and write frames with the select dropped between the two command bytes and between data bytes. It repeats this after switching the bit order through address 0, so that the increment direction and the LSB-first shifting are both exercised while the line turns around. Address wrap through zero, partial-byte aborts and extra clock pulses after a fixed-length frame are each driven on their own and then read back through normal frames.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int CMD_BITS  = 16;
  localparam int ADDR_BITS = 13;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CMD   = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  localparam logic [1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi3w_sync_edge.sv
module spi3w_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_a,
  input  logic csn_a,
  input  logic sdi_a,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csn_s,
  output logic csn_rise,
  output logic csn_fall,
  output logic sdi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b100;

  logic [NSIG-1:0] pins;
  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] last_q;
  logic [NSIG-1:0] cur;

  assign pins = {csn_a, sclk_a, sdi_a};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= pins;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= RST_VAL;
    else     last_q <= cur;
  end

  assign sdi_s     = cur[0];
  assign sclk_rise = cur[1] & ~last_q[1];
  assign sclk_fall = ~cur[1] & last_q[1];
  assign csn_s     = cur[2];
  assign csn_rise  = cur[2] & ~last_q[2];
  assign csn_fall  = ~cur[2] & last_q[2];
endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi3w_frame_ctrl.sv
module spi3w_frame_ctrl
  import spi3w_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter logic [ADDR_BITS-1:0] CFG_ADDR = '0,
  parameter int ORDER_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  input  logic                 csn_s,
  input  logic                 csn_rise,
  input  logic                 csn_fall,
  input  logic                 sdi_s,
  input  logic [BYTE_BITS-1:0] rdata,
  output logic                 we,
  output logic [IDX_W-1:0]     widx,
  output logic [BYTE_BITS-1:0] wdata,
  output logic [IDX_W-1:0]     ridx,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic                 lsb_first
);
  localparam int CNT_W = $clog2(CMD_BITS);
  localparam int BIT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_HALF = CNT_W'(CMD_BITS / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_BITS - 1);

  phase_e                 phase_q;
  logic                   armed_q;
  logic [CNT_W-1:0]       cmd_cnt_q;
  logic [CMD_BITS-2:0]    cmd_sh_q;
  logic                   rd_q;
  logic [1:0]             len_q;
  logic [1:0]             left_q;
  logic [ADDR_BITS-1:0]   addr_q;
  logic [BIT_W-1:0]       bit_q;
  logic [BYTE_BITS-1:0]   byte_sh_q;
  logic                   lsb_q;
  logic                   sdo_q;
  logic                   oe_q;

  logic [CMD_BITS-1:0]    cmd_next;
  logic [BYTE_BITS-1:0]   byte_next;
  logic [ADDR_BITS-1:0]   addr_step;
  logic                   byte_done;
  logic                   tx_bit;
  logic                   selected_rise;
  logic                   at_boundary;

  assign cmd_next      = {cmd_sh_q, sdi_s};
  assign byte_next     = lsb_q ? {sdi_s, byte_sh_q[BYTE_BITS-1:1]}
                               : {byte_sh_q[BYTE_BITS-2:0], sdi_s};
  assign addr_step     = lsb_q ? addr_q + ADDR_BITS'(1) : addr_q - ADDR_BITS'(1);
  assign selected_rise = sclk_rise && !csn_s;
  assign byte_done     = selected_rise && (phase_q == PH_DATA) && (bit_q == BIT_LAST);
  assign tx_bit        = lsb_q ? rdata[bit_q] : rdata[BIT_LAST - bit_q];
  assign at_boundary   = (bit_q == '0) && (len_q != LEN_STREAM);

  assign we    = byte_done && !rd_q;
  assign widx  = addr_q[IDX_W-1:0];
  assign wdata = byte_next;
  assign ridx  = addr_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      armed_q   <= 1'b0;
      cmd_cnt_q <= '0;
      cmd_sh_q  <= '0;
      rd_q      <= 1'b0;
      len_q     <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      bit_q     <= '0;
      byte_sh_q <= '0;
      lsb_q     <= 1'b0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      oe_q <= (phase_q == PH_DATA) && rd_q && !csn_s;
      if (csn_rise) begin
        unique case (phase_q)
          PH_CMD: begin
            if (cmd_cnt_q != CMD_HALF) phase_q <= PH_IDLE;
          end
          PH_DATA: begin
            if (!at_boundary) phase_q <= PH_IDLE;
          end
          default: ;
        endcase
        if (phase_q == PH_IDLE ||
            (phase_q == PH_CMD && cmd_cnt_q != CMD_HALF) ||
            (phase_q == PH_DATA && !at_boundary)) begin
          armed_q <= 1'b0;
        end
      end else if (csn_fall) begin
        armed_q <= 1'b1;
        if (phase_q == PH_DATA && rd_q) sdo_q <= tx_bit;
      end else if (selected_rise) begin
        unique case (phase_q)
          PH_IDLE: begin
            if (armed_q) begin
              cmd_sh_q  <= cmd_next[CMD_BITS-2:0];
              cmd_cnt_q <= CNT_W'(1);
              phase_q   <= PH_CMD;
            end
          end
          PH_CMD: begin
            cmd_sh_q <= cmd_next[CMD_BITS-2:0];
            if (cmd_cnt_q == CMD_LAST) begin
              rd_q    <= cmd_next[CMD_BITS-1];
              len_q   <= cmd_next[CMD_BITS-2 -: 2];
              left_q  <= cmd_next[CMD_BITS-2 -: 2];
              addr_q  <= cmd_next[ADDR_BITS-1:0];
              bit_q   <= '0;
              phase_q <= PH_DATA;
            end else begin
              cmd_cnt_q <= cmd_cnt_q + CNT_W'(1);
            end
          end
          PH_DATA: begin
            byte_sh_q <= byte_next;
            bit_q     <= bit_q + BIT_W'(1);
            if (bit_q == BIT_LAST) begin
              addr_q <= addr_step;
              if (we && addr_q == CFG_ADDR) lsb_q <= byte_next[ORDER_BIT];
              if (len_q != LEN_STREAM) begin
                if (left_q == '0) begin
                  phase_q <= PH_IDLE;
                  armed_q <= 1'b0;
                end else begin
                  left_q <= left_q - 2'd1;
                end
              end
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end else if (sclk_fall && !csn_s && phase_q == PH_DATA && rd_q) begin
        sdo_q <= tx_bit;
      end
    end
  end

  assign sdo       = sdo_q;
  assign sdo_oe    = oe_q;
  assign lsb_first = lsb_q;
endmodule

// File: rtl/spi3w_cfg_slave.sv
module spi3w_cfg_slave
  import spi3w_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_BITS-1:0] CFG_ADDR = '0,
  parameter int ORDER_BIT   = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_oe
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic                 sclk_rise;
  logic                 sclk_fall;
  logic                 csn_s;
  logic                 csn_rise;
  logic                 csn_fall;
  logic                 sdi_s;
  logic                 ram_we;
  logic [IDX_W-1:0]     ram_widx;
  logic [IDX_W-1:0]     ram_ridx;
  logic [BYTE_BITS-1:0] ram_wdata;
  logic [BYTE_BITS-1:0] ram_rdata;
  logic                 lsb_first;

  spi3w_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .sclk_a    (spi_sclk),
    .csn_a     (spi_csn),
    .sdi_a     (spi_sdi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .csn_s     (csn_s),
    .csn_rise  (csn_rise),
    .csn_fall  (csn_fall),
    .sdi_s     (sdi_s)
  );

  spi3w_frame_ctrl #(
    .IDX_W     (IDX_W),
    .CFG_ADDR  (CFG_ADDR),
    .ORDER_BIT (ORDER_BIT)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .csn_s     (csn_s),
    .csn_rise  (csn_rise),
    .csn_fall  (csn_fall),
    .sdi_s     (sdi_s),
    .rdata     (ram_rdata),
    .we        (ram_we),
    .widx      (ram_widx),
    .wdata     (ram_wdata),
    .ridx      (ram_ridx),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe),
    .lsb_first (lsb_first)
  );

  spi3w_regfile #(.DATA_W(BYTE_BITS), .DEPTH(NUM_REGS)) regs_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_widx),
    .wdata (ram_wdata),
    .raddr (ram_ridx),
    .rdata (ram_rdata)
  );
endmodule

// File: rtl/spi3w_cfg_slave_chk.sv
module spi3w_cfg_slave_chk (
  input logic clk,
  input logic rst,
  input logic csn_s,
  input logic sclk_rise,
  input logic ram_we,
  input logic lsb_first,
  input logic spi_sdo,
  input logic spi_sdo_oe
);
  // R7: deselect releases the shared line on the next cycle
  assert_tristate_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !spi_sdo_oe);

  // R6: no register write while the line is being driven
  assert_no_write_when_driving_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !spi_sdo_oe);

  // R9: writes only happen while selected
  assert_write_selected_R9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !csn_s);

  // R12: the output bit is steady when the controller samples it
  assert_sdo_stable_at_rise_R12: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |-> $stable(spi_sdo));

  // R10: bit order only changes as the result of a register write
  assert_order_by_write_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(lsb_first) |-> $past(ram_we));
endmodule

bind spi3w_cfg_slave spi3w_cfg_slave_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .csn_s      (csn_s),
  .sclk_rise  (sclk_rise),
  .ram_we     (ram_we),
  .lsb_first  (lsb_first),
  .spi_sdo    (spi_sdo),
  .spi_sdo_oe (spi_sdo_oe)
);

// File: tb/spi3w_cfg_slave_tb_top.sv
module spi3w_cfg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NUM_REGS   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  logic oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  model [NUM_REGS];
  logic        lsb_m = 1'b0;
  logic [7:0]  wbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3w_cfg_slave #(.NUM_REGS(NUM_REGS)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .spi_sclk   (sclk),
    .spi_csn    (csn),
    .spi_sdi    (sdi),
    .spi_sdo    (sdo),
    .spi_sdo_oe (oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic r, output logic o);
    sdi = b;
    wait_clk(HALF);
    r = sdo;
    o = oe;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic sel();
    csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    csn = 1'b1;
    wait_clk(HALF);
  endtask

  function automatic logic [12:0] step(input logic [12:0] a);
    return lsb_m ? a + 13'd1 : a - 13'd1;
  endfunction

  // R2: command is always MSB-first {dir, len[1:0], addr[12:0]}
  task automatic send_cmd(input logic rw, input logic [1:0] w, input logic [12:0] a, input bit stall);
    logic [15:0] c;
    logic r, o;
    c = {rw, w, a};
    for (int i = 15; i >= 0; i--) begin
      bit_xfer(c[i], r, o);
      if (stall && i == 8) begin
        desel();
        sel();
      end
    end
  endtask

  task automatic byte_xfer(input logic [7:0] wb, input logic lsb, output logic [7:0] rb,
                           output logic oe_all, output logic oe_any);
    logic r, o;
    rb = '0;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      bit_xfer(wb[idx], r, o);
      rb[idx] = r;
      oe_all &= o;
      oe_any |= o;
    end
  endtask

  task automatic model_write(inout logic [12:0] a, input logic [7:0] b);
    logic nl;
    nl = lsb_m;
    model[a % NUM_REGS] = b;
    if (a == 13'd0) nl = b[0];
    a = step(a);
    lsb_m = nl;
  endtask

  task automatic write_frame(input logic [1:0] w, input logic [12:0] a, input int n, input bit stall);
    logic [7:0] rb;
    logic oa, oy;
    sel();
    send_cmd(1'b0, w, a, stall);
    for (int k = 0; k < n; k++) begin
      byte_xfer(wbuf[k], lsb_m, rb, oa, oy);
      chk(!oy, "R6 write frame keeps oe low", 32'(oy), 32'd0);
      model_write(a, wbuf[k]);
      if (stall && k < n - 1) begin
        desel();
        sel();
      end
    end
    desel();
  endtask

  task automatic read_frame(input logic [1:0] w, input logic [12:0] a, input int n,
                            input bit stall, input string tag);
    logic [7:0] rb, exp;
    logic oa, oy;
    sel();
    send_cmd(1'b1, w, a, stall);
    for (int k = 0; k < n; k++) begin
      exp = model[a % NUM_REGS];
      byte_xfer(8'h00, lsb_m, rb, oa, oy);
      chk(rb == exp, tag, 32'(rb), 32'(exp));
      chk(oa, "R6 oe high during read data", 32'(oa), 32'd1);
      a = step(a);
      if (stall && k < n - 1) begin
        desel();
        chk(oe == 1'b0, "R7 oe low in stall", 32'(oe), 32'd0);
        sel();
      end
    end
    desel();
    chk(oe == 1'b0, "R7 oe low after frame", 32'(oe), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] addrs [4];
    logic [7:0] rb;
    logic oa, oy, r, o;
    addrs[0] = 13'd5;
    addrs[1] = 13'd13;
    addrs[2] = 13'd22;
    addrs[3] = 13'h1ABC;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);
    chk(oe == 1'b0, "R1 reset oe", 32'(oe), 32'd0);
    chk(sdo == 1'b0, "R1 reset sdo", 32'(sdo), 32'd0);

    // R2 R3 R5 R11 R12 sweep: every fixed length at several addresses
    for (int ai = 0; ai < 4; ai++) begin
      for (int w = 0; w < 3; w++) begin
        for (int k = 0; k < w + 1; k++)
          wbuf[k] = 8'(int'(addrs[ai]) * 7 + k * 29 + w * 83 + 8'h35);
        write_frame(2'(w), addrs[ai], w + 1, 1'b0);
        read_frame(2'(w), addrs[ai], w + 1, 1'b0, "R5 R12 readback");
        read_frame(2'b10, addrs[ai], 3, 1'b0, "R3 three-byte read");
      end
    end

    // R3: extra clocks after a one-byte frame with select still low
    sel();
    send_cmd(1'b0, 2'b00, 13'd40, 1'b0);
    byte_xfer(8'h5A, lsb_m, rb, oa, oy);
    begin
      logic [12:0] t;
      t = 13'd40;
      model_write(t, 8'h5A);
    end
    byte_xfer(8'hFF, lsb_m, rb, oa, oy);
    desel();
    read_frame(2'b00, 13'd40, 1, 1'b0, "R3 frame ends after one byte");
    read_frame(2'b00, 13'd39, 1, 1'b0, "R3 extra clocks ignored");
    read_frame(2'b00, 13'd8, 1, 1'b0, "R11 alias modulo register count");

    // R4: streaming write and read
    for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'hC1 + k * 17);
    write_frame(2'b11, 13'd20, 6, 1'b0);
    read_frame(2'b11, 13'd20, 6, 1'b0, "R4 streaming readback");

    // R11: decrement wraps through zero (config byte keeps MSB-first)
    wbuf[0] = 8'h6E; wbuf[1] = 8'hA4; wbuf[2] = 8'h3B;
    write_frame(2'b10, 13'd1, 3, 1'b0);
    read_frame(2'b10, 13'd1, 3, 1'b0, "R11 wrap through zero");
    read_frame(2'b00, 13'd31, 1, 1'b0, "R11 top address aliases");

    // R8: stalls at byte boundaries in write and read
    wbuf[0] = 8'h92; wbuf[1] = 8'h4F;
    write_frame(2'b01, 13'd12, 2, 1'b1);
    read_frame(2'b01, 13'd12, 2, 1'b1, "R8 stall keeps position");
    read_frame(2'b00, 13'd11, 1, 1'b0, "R8 second byte placed");

    // R9: abort mid data byte, then mid command
    sel();
    send_cmd(1'b0, 2'b00, 13'd12, 1'b0);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, r, o);
    desel();
    read_frame(2'b00, 13'd12, 1, 1'b0, "R9 partial byte not written");
    sel();
    for (int i = 0; i < 5; i++) bit_xfer(1'b0, r, o);
    desel();
    wbuf[0] = 8'hD7;
    write_frame(2'b00, 13'd9, 1, 1'b0);
    read_frame(2'b00, 13'd9, 1, 1'b0, "R9 recovery after command abort");

    // R10: switch to LSB-first, stream in that order, then switch back
    wbuf[0] = 8'h01;
    write_frame(2'b00, 13'd0, 1, 1'b0);
    chk(lsb_m == 1'b1, "R10 model order flag", 32'(lsb_m), 32'd1);
    wbuf[0] = 8'h1E; wbuf[1] = 8'h87; wbuf[2] = 8'h4D;
    write_frame(2'b10, 13'd24, 3, 1'b0);
    read_frame(2'b10, 13'd24, 3, 1'b1, "R10 LSB-first readback");
    read_frame(2'b00, 13'd0, 1, 1'b0, "R10 config readback");
    wbuf[0] = 8'h00;
    write_frame(2'b00, 13'd0, 1, 1'b0);
    read_frame(2'b10, 13'd26, 3, 1'b0, "R10 R11 stored bytes in MSB view");
    read_frame(2'b00, 13'd0, 1, 1'b0, "R10 config cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule